// File: doc/BRIEF.md
# Peripheral Access Abort Controller

This block decides whether an illegal access on a peripheral bus turns into a bus abort. It holds a 16-bit configuration register that has only two live bits. One enables aborts for accesses to peripheral slots with nothing behind them. The other enables aborts for accesses to reserved offsets inside a peripheral that does exist. A simple register-bus slave port reads and writes the register, and it checks the width and alignment of each access.

A second channel carries every peripheral access. Each access comes with its address, its direction and its size, plus a flag for an unpopulated slot, a flag for a reserved offset, and a flag for an abort already raised upstream by the bus bridge. An upstream abort passes through whatever the enables hold. One cycle after the access, in its response phase, the block raises a one-cycle abort pulse. The pulse is tagged as an instruction-fetch abort or as a data abort, and it carries the access's address, direction and size.

Top module: `pab_ctrl`

## Requirements
- R1: After reset every bit of the configuration register is 0, so a 16-bit read at offset 0x6 returns 0 and neither abort enable is active.
- R2: Register reads succeed at 8-bit (size code 0), 16-bit (code 1, even address) and 32-bit (code 2, address 0x4) width. The register sits big-endian at byte offsets 0x6 (high byte) and 0x7 (low byte), and the data returns right-aligned in the read data.
- R3: A 32-bit register write returns an error response and leaves the register unchanged.
- R4: An 8-bit write changes only the addressed byte lane, taking its data from write-data bits 7:0. An 8-bit write at 0x6 changes nothing.
- R5: Only register bits 1 (slot enable) and 0 (reserved-offset enable) can be written. All other bits read as 0, whatever was written to them.
- R6: With the slot enable at 1, an access flagged as an unpopulated slot aborts. With it at 0, such an access does not abort.
- R7: With the reserved-offset enable at 1, an access flagged as a reserved offset aborts. With it at 0, such an access does not abort.
- R8: An access flagged as aborted by the bridge always aborts, whatever the two enables hold.
- R9: An abort raises the fetch-abort output when the access was a fetch, and the data-abort output otherwise. The two are never high together.
- R10: An abort is signalled one cycle after the access, for exactly one cycle per access. Nothing is signalled without an access.
- R11: An access flagged both as an unpopulated slot and as a reserved offset gives a single abort if either enable is set.
- R12: A register access outside the word at 0x4, a misaligned access, or size code 3 returns an error response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rb_valid | input | 1 | Register access request |
| rb_write | input | 1 | 1 = write, 0 = read |
| rb_size | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = invalid |
| rb_addr | input | 12 | Byte address within the block |
| rb_wdata | input | 16 | Write data, right-aligned |
| rb_resp_valid | output | 1 | Response phase of a register access |
| rb_resp_err | output | 1 | Error response |
| rb_rdata | output | 32 | Read data, right-aligned |
| pa_valid | input | 1 | Peripheral access present |
| pa_addr | input | 32 | Peripheral access address |
| pa_write | input | 1 | Peripheral access direction |
| pa_size | input | 2 | Peripheral access size |
| pa_fetch | input | 1 | Access is an instruction fetch |
| pa_noslot | input | 1 | Target slot has no peripheral |
| pa_rsvd | input | 1 | Target is a reserved offset |
| pa_bridge_abort | input | 1 | Bridge already aborted the access |
| ab_fetch | output | 1 | Instruction-fetch abort pulse |
| ab_data | output | 1 | Data abort pulse |
| ab_addr | output | 32 | Address of the aborted access |
| ab_write | output | 1 | Direction of the aborted access |
| ab_size | output | 2 | Size of the aborted access |

## Verification
The bench builds the block with its default parameters: a 12-bit register address, the register at offset 0x6 and an implemented-bit mask of 0x0003. With the register in the upper half of its word, every lane and half-word path of the read shaper and the write enables can be reached. Because only the low lane holds live bits, writes to the high lane and to unimplemented bits leave visible evidence, which the bench reads back. Abort tests walk all four enable settings against each flag combination, and include back-to-back accesses.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } pab_size_e;

  localparam int EN_RSVD_BIT = 0;
  localparam int EN_SLOT_BIT = 1;

  // Alignment rule shared by reads and writes
  function automatic logic size_aligned(input logic [1:0] size, input logic [1:0] lo2);
    case (size)
      SZ_BYTE: size_aligned = 1'b1;
      SZ_HALF: size_aligned = ~lo2[0];
      SZ_WORD: size_aligned = (lo2 == 2'b00);
      default: size_aligned = 1'b0;
    endcase
  endfunction

  // Picks the addressed bytes out of a big-endian word image, right-aligned
  function automatic logic [31:0] read_shape(input logic [1:0] size, input logic [1:0] lo2,
                                             input logic [31:0] img);
    logic [31:0] r;
    r = '0;
    case (size)
      SZ_WORD: r = img;
      SZ_HALF: r[15:0] = lo2[1] ? img[15:0] : img[31:16];
      SZ_BYTE: begin
        case (lo2)
          2'd0: r[7:0] = img[31:24];
          2'd1: r[7:0] = img[23:16];
          2'd2: r[7:0] = img[15:8];
          default: r[7:0] = img[7:0];
        endcase
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Abort decision for one access
  function automatic logic abort_needed(input logic bridge, input logic noslot, input logic rsvd,
                                        input logic en_slot, input logic en_rsvd);
    return bridge | (noslot & en_slot) | (rsvd & en_rsvd);
  endfunction

endpackage

// File: rtl/pab_cfg_reg.sv
module pab_cfg_reg
  import pab_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [11:0]     REG_OFFSET = 12'h006,
  parameter logic [15:0]     IMPL_MASK  = 16'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_valid,
  input  logic              rb_write,
  input  logic [1:0]        rb_size,
  input  logic [ADDR_W-1:0] rb_addr,
  input  logic [15:0]       rb_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [31:0]       resp_rdata,
  output logic [15:0]       cfg_out
);

  localparam int              WORD_W   = ADDR_W - 2;
  localparam logic [WORD_W-1:0] REG_WORD = REG_OFFSET[ADDR_W-1:2];
  localparam logic [1:0]      HI_LANE  = {REG_OFFSET[1], 1'b0};
  localparam logic [1:0]      LO_LANE  = {REG_OFFSET[1], 1'b1};

  logic [1:0]  lo2;
  logic        word_hit;
  logic        aligned;
  logic        req_err;
  logic        wr_hi;
  logic        wr_lo;
  logic [7:0]  hi_data;
  logic [15:0] wr_val;
  logic [15:0] cfg_q;
  logic [31:0] img;
  logic        wr_unused;

  assign lo2      = rb_addr[1:0];
  assign word_hit = (rb_addr[ADDR_W-1:2] == REG_WORD);
  assign aligned  = size_aligned(rb_size, lo2);
  assign req_err  = !word_hit || !aligned || (rb_write && rb_size == SZ_WORD);

  assign wr_hi = rb_valid && rb_write && !req_err &&
                 ((rb_size == SZ_HALF && lo2 == HI_LANE) || (rb_size == SZ_BYTE && lo2 == HI_LANE));
  assign wr_lo = rb_valid && rb_write && !req_err &&
                 ((rb_size == SZ_HALF && lo2 == HI_LANE) || (rb_size == SZ_BYTE && lo2 == LO_LANE));

  assign hi_data   = (rb_size == SZ_BYTE) ? rb_wdata[7:0] : rb_wdata[15:8];
  assign wr_val    = {hi_data, rb_wdata[7:0]} & IMPL_MASK;
  assign wr_unused = ^(wr_val & ~IMPL_MASK);

  for (genvar i = 0; i < 16; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      bit_q <= 1'b0;
        else if ((i >= 8) ? wr_hi : wr_lo) bit_q <= wr_val[i];
      end
      assign cfg_q[i] = bit_q;
    end else begin : g_tied
      assign cfg_q[i] = 1'b0;
    end
  end

  assign cfg_out = cfg_q;
  assign img     = REG_OFFSET[1] ? {16'h0000, cfg_q} : {cfg_q, 16'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= rb_valid;
      resp_err   <= rb_valid && req_err;
      resp_rdata <= (rb_valid && !rb_write && !req_err) ? read_shape(rb_size, lo2, img) : '0;
    end
  end

  // R3: a wide write is refused and leaves the register as it was
  a_r3_wide_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_write && rb_size == SZ_WORD) |=> $stable(cfg_out));
  a_r3_wide_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_write && rb_size == SZ_WORD) |=> (resp_valid && resp_err));
  // R12: an erroneous access never changes the register
  a_r12_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && req_err) |=> $stable(cfg_out));
  // R2: an aligned read inside the register word is accepted
  a_r2_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_write && word_hit && aligned) |=> (resp_valid && !resp_err));
  // R5: read data never carries unimplemented bits
  a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ((resp_rdata & ~{16'h0000, IMPL_MASK}) == 32'h0));

endmodule

// File: rtl/pab_abort_gate.sv
module pab_abort_gate
  import pab_pkg::*;
#(
  parameter int PADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_slot,
  input  logic               en_rsvd,
  input  logic               pa_valid,
  input  logic [PADDR_W-1:0] pa_addr,
  input  logic               pa_write,
  input  logic [1:0]         pa_size,
  input  logic               pa_fetch,
  input  logic               pa_noslot,
  input  logic               pa_rsvd,
  input  logic               pa_bridge_abort,
  output logic               ab_fetch,
  output logic               ab_data,
  output logic [PADDR_W-1:0] ab_addr,
  output logic               ab_write,
  output logic [1:0]         ab_size
);

  logic abort_now;

  assign abort_now = pa_valid && abort_needed(pa_bridge_abort, pa_noslot, pa_rsvd, en_slot, en_rsvd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_fetch <= 1'b0;
      ab_data  <= 1'b0;
      ab_addr  <= '0;
      ab_write <= 1'b0;
      ab_size  <= '0;
    end else begin
      ab_fetch <= abort_now && pa_fetch;
      ab_data  <= abort_now && !pa_fetch;
      if (abort_now) begin
        ab_addr  <= pa_addr;
        ab_write <= pa_write;
        ab_size  <= pa_size;
      end
    end
  end

  // R9: fetch and data aborts are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ab_fetch && ab_data));
  // R8: a bridge abort always comes out
  a_r8_bridge_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_bridge_abort) |=> (ab_fetch || ab_data));
  // R6: an enabled unpopulated-slot access aborts
  a_r6_slot_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_noslot && en_slot) |=> (ab_fetch || ab_data));
  // R7: an enabled reserved-offset access aborts
  a_r7_rsvd_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_rsvd && en_rsvd) |=> (ab_fetch || ab_data));
  // R10: no access, no abort in the next cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_valid |=> !(ab_fetch || ab_data));

endmodule

// File: rtl/pab_ctrl.sv
module pab_ctrl
  import pab_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          PADDR_W    = 32,
  parameter logic [11:0] REG_OFFSET = 12'h006,
  parameter logic [15:0] IMPL_MASK  = 16'h0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rb_valid,
  input  logic               rb_write,
  input  logic [1:0]         rb_size,
  input  logic [ADDR_W-1:0]  rb_addr,
  input  logic [15:0]        rb_wdata,
  output logic               rb_resp_valid,
  output logic               rb_resp_err,
  output logic [31:0]        rb_rdata,
  input  logic               pa_valid,
  input  logic [PADDR_W-1:0] pa_addr,
  input  logic               pa_write,
  input  logic [1:0]         pa_size,
  input  logic               pa_fetch,
  input  logic               pa_noslot,
  input  logic               pa_rsvd,
  input  logic               pa_bridge_abort,
  output logic               ab_fetch,
  output logic               ab_data,
  output logic [PADDR_W-1:0] ab_addr,
  output logic               ab_write,
  output logic [1:0]         ab_size
);

  logic [15:0] cfg;
  logic        en_slot;
  logic        en_rsvd;
  logic        cfg_unused;

  pab_cfg_reg #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET),
    .IMPL_MASK  (IMPL_MASK)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_valid   (rb_valid),
    .rb_write   (rb_write),
    .rb_size    (rb_size),
    .rb_addr    (rb_addr),
    .rb_wdata   (rb_wdata),
    .resp_valid (rb_resp_valid),
    .resp_err   (rb_resp_err),
    .resp_rdata (rb_rdata),
    .cfg_out    (cfg)
  );

  assign en_slot    = cfg[EN_SLOT_BIT];
  assign en_rsvd    = cfg[EN_RSVD_BIT];
  assign cfg_unused = ^cfg[15:2];

  pab_abort_gate #(
    .PADDR_W (PADDR_W)
  ) u_gate (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_slot         (en_slot),
    .en_rsvd         (en_rsvd),
    .pa_valid        (pa_valid),
    .pa_addr         (pa_addr),
    .pa_write        (pa_write),
    .pa_size         (pa_size),
    .pa_fetch        (pa_fetch),
    .pa_noslot       (pa_noslot),
    .pa_rsvd         (pa_rsvd),
    .pa_bridge_abort (pa_bridge_abort),
    .ab_fetch        (ab_fetch),
    .ab_data         (ab_data),
    .ab_addr         (ab_addr),
    .ab_write        (ab_write),
    .ab_size         (ab_size)
  );

endmodule

// File: tb/pab_ctrl_test.sv
`timescale 1ns/1ps
module pab_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rb_valid = 0, rb_write = 0;
  logic [1:0]  rb_size = 0;
  logic [11:0] rb_addr = 0;
  logic [15:0] rb_wdata = 0;
  logic        rb_resp_valid, rb_resp_err;
  logic [31:0] rb_rdata;
  logic        pa_valid = 0, pa_write = 0, pa_fetch = 0, pa_noslot = 0, pa_rsvd = 0, pa_bridge_abort = 0;
  logic [31:0] pa_addr = 0;
  logic [1:0]  pa_size = 0;
  logic        ab_fetch, ab_data, ab_write;
  logic [31:0] ab_addr;
  logic [1:0]  ab_size;

  int checks = 0;
  int fails = 0;
  logic [1:0] model_en = 2'b00;  // bit1 slot enable, bit0 reserved-offset enable

  always #5 clk = ~clk;

  pab_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .rb_valid(rb_valid), .rb_write(rb_write), .rb_size(rb_size), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .rb_resp_valid(rb_resp_valid), .rb_resp_err(rb_resp_err),
    .rb_rdata(rb_rdata), .pa_valid(pa_valid), .pa_addr(pa_addr), .pa_write(pa_write),
    .pa_size(pa_size), .pa_fetch(pa_fetch), .pa_noslot(pa_noslot), .pa_rsvd(pa_rsvd),
    .pa_bridge_abort(pa_bridge_abort), .ab_fetch(ab_fetch), .ab_data(ab_data),
    .ab_addr(ab_addr), .ab_write(ab_write), .ab_size(ab_size)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: predict from driven inputs, advance, compare at the falling edge
  task automatic step(input string tag);
    logic [31:0] img, exp_rd;
    logic        exp_err, exp_abort, exp_f, exp_d;
    logic [1:0]  next_en;
    int          k;
    img = {30'd0, model_en};
    k = int'(rb_addr[1:0]);
    exp_err = (rb_addr[11:2] != 10'd1) || (rb_size == 2'd3) ||
              (rb_size == 2'd1 && rb_addr[0]) || (rb_size == 2'd2 && rb_addr[1:0] != 0) ||
              (rb_write && rb_size == 2'd2);
    exp_rd = 0;
    if (rb_valid && !rb_write && !exp_err) begin
      if (rb_size == 2'd2) exp_rd = img;
      else if (rb_size == 2'd1) exp_rd = {16'd0, img[31-8*k -: 8], img[23-8*k -: 8]};
      else exp_rd = {24'd0, img[31-8*k -: 8]};
    end
    next_en = model_en;
    if (rb_valid && rb_write && !exp_err) begin
      if ((rb_size == 2'd0 && k == 3) || (rb_size == 2'd1 && k == 2)) next_en = rb_wdata[1:0];
    end
    exp_abort = pa_valid && (pa_bridge_abort || (pa_noslot && model_en[1]) || (pa_rsvd && model_en[0]));
    exp_f = exp_abort && pa_fetch;
    exp_d = exp_abort && !pa_fetch;
    @(posedge clk);
    @(negedge clk);
    check(tag, "resp_valid", {31'd0, rb_resp_valid}, {31'd0, rb_valid});
    if (rb_valid) begin
      check(tag, "resp_err", {31'd0, rb_resp_err}, {31'd0, exp_err});
      check(tag, "rdata", rb_rdata, exp_rd);
    end
    check(tag, "abort fetch", {31'd0, ab_fetch}, {31'd0, exp_f});
    check(tag, "abort data", {31'd0, ab_data}, {31'd0, exp_d});
    if (exp_abort) check(tag, "abort addr", ab_addr, pa_addr);
    model_en = next_en;
    rb_valid = 0; rb_write = 0;
    pa_valid = 0; pa_fetch = 0; pa_noslot = 0; pa_rsvd = 0; pa_bridge_abort = 0;
  endtask

  task automatic reg_op(input string tag, input logic wr, input logic [1:0] sz,
                        input logic [11:0] a, input logic [15:0] d);
    rb_valid = 1; rb_write = wr; rb_size = sz; rb_addr = a; rb_wdata = d;
    step(tag);
  endtask

  task automatic pa_op(input string tag, input logic [31:0] a, input logic f, input logic ns,
                       input logic rs, input logic br);
    pa_valid = 1; pa_addr = a; pa_write = a[2]; pa_size = 2'd2;
    pa_fetch = f; pa_noslot = ns; pa_rsvd = rs; pa_bridge_abort = br;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset abort", {30'd0, ab_fetch, ab_data}, 32'd0);
    check("R1", "reset resp", {31'd0, rb_resp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    reg_op("R1", 0, 2'd1, 12'h006, 0);
    pa_op("R1", 32'h1000, 0, 1, 1, 0);
    // R6 slot enable
    pa_op("R6", 32'h1100, 0, 1, 0, 0);
    reg_op("R6", 1, 2'd1, 12'h006, 16'h0002);
    pa_op("R6", 32'h1200, 0, 1, 0, 0);
    pa_op("R9", 32'h1300, 1, 1, 0, 0);
    pa_op("R7", 32'h1400, 0, 0, 1, 0);
    // R4 byte write to low lane replaces both enables
    reg_op("R4", 1, 2'd0, 12'h007, 16'hAB01);
    pa_op("R7", 32'h1500, 1, 0, 1, 0);
    pa_op("R6", 32'h1600, 0, 1, 0, 0);
    reg_op("R4", 1, 2'd0, 12'h006, 16'h00FF);
    reg_op("R4", 0, 2'd1, 12'h006, 0);
    // R5 unimplemented bits
    reg_op("R5", 1, 2'd1, 12'h006, 16'hFFFF);
    reg_op("R5", 0, 2'd2, 12'h004, 0);
    // R3 wide write refused
    reg_op("R3", 1, 2'd2, 12'h004, 16'h0000);
    reg_op("R3", 0, 2'd1, 12'h006, 0);
    // R2 read widths
    reg_op("R2", 0, 2'd0, 12'h007, 0);
    reg_op("R2", 0, 2'd0, 12'h006, 0);
    reg_op("R2", 0, 2'd0, 12'h004, 0);
    reg_op("R2", 0, 2'd1, 12'h004, 0);
    reg_op("R2", 0, 2'd2, 12'h004, 0);
    // R12 bad accesses
    reg_op("R12", 0, 2'd1, 12'h008, 0);
    reg_op("R12", 1, 2'd1, 12'h007, 16'h0000);
    reg_op("R12", 1, 2'd3, 12'h006, 16'h0000);
    reg_op("R12", 1, 2'd1, 12'h106, 16'h0000);
    reg_op("R12", 0, 2'd2, 12'h006, 0);
    // R11 both flags, R10 back-to-back and idle
    pa_op("R11", 32'h2000, 0, 1, 1, 0);
    step("R10");
    reg_op("R11", 1, 2'd1, 12'h006, 16'h0001);
    pa_op("R11", 32'h2100, 1, 1, 1, 0);
    pa_op("R10", 32'h2200, 0, 0, 1, 0);
    pa_op("R10", 32'h2300, 1, 0, 1, 0);
    step("R10");
    // R8 bridge aborts bypass enables
    reg_op("R8", 1, 2'd1, 12'h006, 16'h0000);
    pa_op("R8", 32'h3000, 0, 0, 0, 1);
    pa_op("R8", 32'h3100, 1, 1, 1, 1);
    pa_op("R11", 32'h3200, 0, 1, 1, 0);
    // concurrent write and access: access sees the old enables
    rb_valid = 1; rb_write = 1; rb_size = 2'd1; rb_addr = 12'h006; rb_wdata = 16'h0002;
    pa_valid = 1; pa_addr = 32'h3300; pa_noslot = 1;
    step("R6");
    pa_op("R6", 32'h3400, 0, 1, 0, 0);
    step("R10");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule